// File: doc/BRIEF.md
# Long-Period Wakeup Down-Counter Timer

This block measures long sleep intervals using a wide down counter. The counter advances only when a slow-clock tick arrives; that tick is a single-cycle enable in the fast clock domain, and the slow oscillator behind it lies outside this block. Software writes a start value, and the write begins the countdown. When the count goes from one to zero, a sticky expiry flag is set. The flag, gated by an interrupt enable, forms the wakeup/interrupt output.

The counter does not halt at zero. It keeps counting into negative two's-complement values until software stops it. Negating the frozen count therefore gives the number of slow ticks that passed between expiry and the software response. A stop command freezes the count for readout. The interrupt enable only gates the output, so software should set it before loading the count.

Top module: `wkup_timer`

## Requirements
- R1: A load pulse puts `load_val` into the count on the next cycle, sets `running` and clears the expiry flag. Load takes precedence over stop, tick and flag clear in the same cycle.
- R2: While running, each cycle with `tick_en` high and no load or stop lowers the count by exactly one.
- R3: A cycle without `tick_en` leaves the count unchanged.
- R4: The expiry flag sets on the cycle after a tick that moves the count from 1 to 0 while running.
- R5: Below zero the count wraps in two's complement: 0 becomes all ones, and the negated count equals the ticks elapsed since zero. Loading 0 and ticking gives all ones without setting the flag.
- R6: The flag is sticky until `flag_clr` is pulsed. If a clear and an expiry happen in the same cycle, the expiry wins.
- R7: `event_o` is high exactly when the flag is set and `irq_en` is high, with no cycle of delay relative to either.
- R8: A stop pulse clears `running`. The count then stays frozen through later ticks, and the flag is not changed by the stop.
- R9: After reset the count is 0, and the flag, `running` and `event_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle slow-clock tick enable |
| load_vld | input | 1 | Load start value and begin countdown |
| load_val | input | 35 | Start value |
| stop | input | 1 | Freeze the counter |
| irq_en | input | 1 | Interrupt/wakeup enable |
| flag_clr | input | 1 | Clear the expiry flag |
| count | output | 35 | Current count, two's complement below zero |
| running | output | 1 | Counter is active |
| flag | output | 1 | Sticky expiry flag |
| event_o | output | 1 | Wakeup/interrupt event |

## Verification
Directed sequences first load small values and tick through zero and past it. This separates a correct 1-to-0 expiry and a correct wrap from off-by-one errors and from a counter that saturates at zero. Several same-cycle collisions are driven on purpose: load with stop, clear with expiry, and stop with tick. These expose wrong priorities. Loads of zero and of the largest value exercise both ends of the range. A seeded random phase then mixes sparse loads, stops, clears and enable toggles with dense ticks, and compares every output on every cycle against a bench model.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned WKT_CNT_W = 35;

  typedef struct packed {
    logic do_load;
    logic do_dec;
    logic do_stop;
  } wkt_cmd_t;
endpackage

// File: rtl/wkt_ctrl.sv
module wkt_ctrl
  import wkt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_en,
  input  logic     load_vld,
  input  logic     stop,
  output wkt_cmd_t cmd,
  output logic     run_q
);
  logic run_d;

  // command decode: load dominates, stop blocks a tick in the same cycle
  always_comb begin
    cmd.do_load = load_vld;
    cmd.do_stop = stop & ~load_vld;
    cmd.do_dec  = run_q & tick_en & ~load_vld & ~stop;
  end

  always_comb begin
    run_d = run_q;
    if (cmd.do_load)      run_d = 1'b1;
    else if (cmd.do_stop) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = WKT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wkt_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = cmd.do_load | cmd.do_dec;
    cnt_d  = cnt_q;
    if (cmd.do_load)     cnt_d = load_val;
    else if (cmd.do_dec) cnt_d = cnt_q - ONE;   // wraps modulo 2^CNT_W
  end

  assign at_one = (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wkt_expiry.sv
module wkt_expiry
  import wkt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wkt_cmd_t cmd,
  input  logic     at_one,
  input  logic     flag_clr,
  input  logic     irq_en,
  output logic     flag_q,
  output logic     event_o
);
  logic flag_d;
  logic hit;

  always_comb begin
    hit    = cmd.do_dec & at_one;
    flag_d = flag_q;
    if (cmd.do_load) flag_d = 1'b0;
    else if (hit)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign event_o = flag_q & irq_en;
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = WKT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_vld,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             flag,
  output logic             event_o
);
  wkt_cmd_t cmd;
  logic     at_one;

  wkt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_vld (load_vld),
    .stop     (stop),
    .cmd      (cmd),
    .run_q    (running)
  );

  wkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .load_val (load_val),
    .cnt_q    (count),
    .at_one   (at_one)
  );

  wkt_expiry u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .at_one   (at_one),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flag_q   (flag),
    .event_o  (event_o)
  );
endmodule

// File: rtl/wkt_chk.sv
module wkt_chk #(
  parameter int unsigned CNT_W = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             load_vld,
  input logic [CNT_W-1:0] load_val,
  input logic             stop,
  input logic             irq_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             flag,
  input logic             event_o
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |=> (count == $past(load_val)) && running && !flag);

  a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && !load_vld && !stop |=> count == $past(count) - CNT_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !load_vld |=> $stable(count));

  a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && !load_vld && !stop && count == CNT_W'(1) |=> flag);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr && !load_vld |=> flag);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !event_o);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !load_vld |=> $stable(count));
endmodule

bind wkup_timer wkt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_vld(load_vld),
  .load_val(load_val), .stop(stop), .irq_en(irq_en), .flag_clr(flag_clr),
  .count(count), .running(running), .flag(flag), .event_o(event_o)
);

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb_top;
  localparam int W = 35;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_en, load_vld, stop, irq_en, flag_clr;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic         running, flag, event_o;

  always #4 clk = ~clk;

  wkup_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_vld(load_vld),
    .load_val(load_val), .stop(stop), .irq_en(irq_en), .flag_clr(flag_clr),
    .count(count), .running(running), .flag(flag), .event_o(event_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_cnt;
  logic         m_run, m_flag;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the requirements, advanced once per clock
  function automatic void model_step();
    logic set;
    set = !load_vld && m_run && tick_en && !stop && (m_cnt == W'(1));
    if (load_vld)      m_flag = 1'b0;
    else if (set)      m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    if (load_vld) begin
      m_cnt = load_val; m_run = 1'b1;
    end else if (stop) begin
      m_run = 1'b0;
    end else if (m_run && tick_en) begin
      m_cnt = m_cnt - W'(1);
    end
  endfunction

  task automatic cycle();
    @(posedge clk);
    model_step();
    #2;
    tick_en = 0; load_vld = 0; stop = 0; flag_clr = 0;
  endtask

  task automatic cmp_all(string tag);
    check({tag, " count"},   count,   m_cnt);
    check({tag, " flag"},    flag,    m_flag);
    check({tag, " running"}, running, m_run);
    check({tag, " event"},   event_o, m_flag & irq_en);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst_n = 0; tick_en = 0; load_vld = 0; stop = 0; irq_en = 0; flag_clr = 0;
    load_val = '0;
    m_cnt = '0; m_run = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R9 reset state
    check("R9 count", count, '0);
    check("R9 flag", flag, 0);
    check("R9 running", running, 0);
    check("R9 event", event_o, 0);

    load_vld = 1; load_val = W'(3); cycle();
    check("R1 count", count, W'(3));
    check("R1 running", running, 1);
    cycle(); cycle();
    check("R3 no tick", count, W'(3));
    tick_en = 1; cycle(); tick_en = 1; cycle();
    check("R2 dec", count, W'(1));
    check("R4 not yet", flag, 0);
    tick_en = 1; cycle();
    check("R4 zero", count, '0);
    check("R4 flag", flag, 1);
    check("R7 masked", event_o, 0);
    irq_en = 1; #1;
    check("R7 enabled", event_o, 1);
    for (int i = 0; i < 5; i++) begin tick_en = 1; cycle(); end
    check("R5 wrap", count, ALL1 - W'(4));
    check("R5 elapsed", -count, W'(5));
    check("R6 sticky", flag, 1);
    stop = 1; tick_en = 1; cycle();
    check("R8 stop count", count, ALL1 - W'(4));
    check("R8 running", running, 0);
    for (int i = 0; i < 3; i++) begin tick_en = 1; cycle(); end
    check("R8 frozen", count, ALL1 - W'(4));
    check("R8 flag kept", flag, 1);
    flag_clr = 1; cycle();
    check("R6 clear", flag, 0);
    check("R7 event low", event_o, 0);
    load_vld = 1; load_val = W'(1); stop = 1; tick_en = 1; cycle();
    check("R1 priority count", count, W'(1));
    check("R1 priority running", running, 1);
    tick_en = 1; flag_clr = 1; cycle();
    check("R6 set wins", flag, 1);
    load_vld = 1; load_val = ALL1; cycle();
    check("R1 flag cleared", flag, 0);
    check("R1 max", count, ALL1);
    tick_en = 1; cycle();
    check("R2 max dec", count, ALL1 - W'(1));
    load_vld = 1; load_val = '0; cycle();
    tick_en = 1; cycle();
    check("R5 load zero", count, ALL1);
    check("R5 no flag", flag, 0);

    // seeded random mix, every output compared each cycle
    for (int i = 0; i < 3000; i++) begin
      load_vld = ($urandom % 64) == 0;
      load_val = ($urandom % 2) ? W'($urandom % 20) : W'({$urandom, $urandom});
      stop     = ($urandom % 50) == 0;
      tick_en  = ($urandom % 2) == 0;
      flag_clr = ($urandom % 40) == 0;
      if (($urandom % 16) == 0) irq_en = ~irq_en;
      cycle();
      cmp_all("random R2 R4 R6 R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule